// File: doc/BRIEF.md
# Multichannel DAC Update Controller

This block is the digital core of a 40-channel, 12-bit voltage DAC. Each channel holds an input code, a gain code and an offset code. From these the block derives a corrected code and, when asked, copies it into the channel's output register, which drives the converter. A single write port selects a channel and one of its registers, or a shared clear-value register. One shared arithmetic unit recomputes corrected codes one channel at a time. Channels written while the unit is occupied are queued, and the active-low busy output stays low until the queue is empty.

Output registers change in only three ways. A load request on the active-low load input copies corrected codes. A low on the active-low clear input fills every output with the clear value. A falling edge on the active-low soft reset input starts a timed reset sequence. A load request that arrives while the block is busy is remembered and applied as soon as busy returns high. A load copies only those channels whose corrected code has been written since the previous load.

Top module: `dac_update_ctrl`

## Requirements
- R1: After the power-on reset input `rst_n` is released, `busy_n` is low for `RST_CYC` cycles, and every channel output reads 0.
- R2: The soft reset sequence starts only on a falling edge of `sreset_n`. Holding `sreset_n` low after the sequence, or raising it, has no effect, and writes and loads then work normally.
- R3: A reset (power-on or soft) sets every gain to 4095, every offset to 2048 (no correction), every input code and the clear value to 0, and every output register to 0.
- R4: `busy_n` is low for the whole soft reset sequence. Writes and load requests during the sequence are discarded.
- R5: A write with `wr_sel` 0 (input), 1 (gain) or 2 (offset) to a channel below 40 starts a recompute of that channel, and `busy_n` is low from the next cycle. While `busy_n` is low, no output register is loaded.
- R6: The corrected code is floor(input × (gain + 1) / 4096) + offset − 2048, saturated to the range 0 to 4095.
- R7: Outputs change only on a load. A load happens when `ldac_n` is low while the block is not busy. A falling edge of `ldac_n` during busy is latched and applied right after `busy_n` rises.
- R8: With `ldac_n` held low, every recompute is loaded right after `busy_n` returns high.
- R9: A load copies a channel's corrected code only if that code has been written since the channel was last loaded or cleared. Other channels keep their output.
- R10: `wr_sel` 3 writes the clear value without starting a recompute. A low on `clr_n`, outside the reset sequence, copies the clear value into every output register and marks no channel as changed.
- R11: Writes to several channels while busy are all recomputed one after another, and `busy_n` stays low until none remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 6 | Channel index of the write |
| wr_sel | input | 2 | 0 input, 1 gain, 2 offset, 3 clear value |
| wr_data | input | 12 | Write data |
| sreset_n | input | 1 | Soft reset, falling-edge triggered |
| clr_n | input | 1 | Clear outputs to the clear value, active low |
| ldac_n | input | 1 | Load outputs, active low |
| busy_n | output | 1 | Low while resetting or recomputing |
| rd_ch | input | 6 | Channel whose output register is shown |
| rd_code | output | 12 | Output register of channel `rd_ch` |

## Verification
The bench keeps all 40 channels but shortens the reset sequence to 20 cycles and sets the recompute time to 4 cycles. With these values the whole reset window can be watched cycle by cycle, and busy lasts long enough that load pulses, back-to-back writes and output reads can all fall inside one busy period. The gain and offset corners exercise saturation at both ends and the truncating division of the gain product.

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl #(
  parameter int NCH      = 40,
  parameter int DW       = 12,
  parameter int RST_CYC  = 4096,
  parameter int CALC_CYC = 4,
  localparam int CW = $clog2(NCH),
  localparam int RW = $clog2(RST_CYC + 1),
  localparam int KW = $clog2(CALC_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_ch,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          sreset_n,
  input  logic          clr_n,
  input  logic          ldac_n,
  output logic          busy_n,
  input  logic [CW-1:0] rd_ch,
  output logic [DW-1:0] rd_code
);
  localparam logic [DW-1:0] FULL  = {DW{1'b1}};
  localparam logic [DW:0]   MID   = (DW+1)'(1 << (DW-1));
  localparam logic [CW:0]   NCH_V = (CW+1)'(NCH);

  logic [DW-1:0] in_r [NCH];
  logic [DW-1:0] gain_r [NCH];
  logic [DW-1:0] off_r [NCH];
  logic [DW-1:0] corr_r [NCH];
  logic [DW-1:0] dac_r [NCH];
  logic [DW-1:0] clr_r;
  logic [NCH-1:0] dirty, pend;
  logic [RW-1:0] rcnt;
  logic [KW-1:0] kcnt;
  logic [CW-1:0] cch, nxt;
  logic sr_q, ld_q, ld_req, calc_on;

  wire rst_busy = rcnt != '0;
  wire sr_fall  = sr_q & ~sreset_n & ~rst_busy;
  wire busy     = rst_busy | calc_on | (|pend);
  wire wr_ok    = wr_en & ~rst_busy & ({1'b0, wr_ch} < NCH_V);
  wire do_clr   = ~clr_n & ~rst_busy;
  wire load     = ~busy & (~ldac_n | ld_req);

  assign busy_n  = ~busy;
  assign rd_code = ({1'b0, rd_ch} < NCH_V) ? dac_r[rd_ch] : '0;

  always_comb begin
    nxt = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) nxt = CW'(i);
  end

  logic [DW:0]     g1;
  logic [2*DW:0]   prod;
  logic [DW-1:0]   scaled;
  logic [DW:0]     sum;
  logic [DW-1:0]   res;
  always_comb begin
    g1     = {1'b0, gain_r[cch]} + (DW+1)'(1);
    prod   = {{(DW+1){1'b0}}, in_r[cch]} * {{DW{1'b0}}, g1};
    scaled = prod[2*DW-1:DW];
    sum    = {1'b0, scaled} + {1'b0, off_r[cch]};
    if (sum < MID)               res = '0;
    else if (sum - MID > {1'b0, FULL}) res = FULL;
    else                         res = DW'(sum - MID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        in_r[i] <= '0; gain_r[i] <= FULL; off_r[i] <= MID[DW-1:0];
        corr_r[i] <= '0; dac_r[i] <= '0;
      end
      clr_r <= '0; dirty <= '0; pend <= '0;
      rcnt <= RW'(RST_CYC); kcnt <= '0; cch <= '0;
      sr_q <= 1'b1; ld_q <= 1'b1; ld_req <= 1'b0; calc_on <= 1'b0;
    end else begin
      sr_q <= sreset_n;
      ld_q <= ldac_n;
      if (sr_fall) begin
        for (int i = 0; i < NCH; i++) begin
          in_r[i] <= '0; gain_r[i] <= FULL; off_r[i] <= MID[DW-1:0];
          corr_r[i] <= '0; dac_r[i] <= '0;
        end
        clr_r <= '0; dirty <= '0; pend <= '0;
        rcnt <= RW'(RST_CYC); kcnt <= '0;
        ld_req <= 1'b0; calc_on <= 1'b0;
      end else begin
        if (rst_busy) rcnt <= rcnt - 1'b1;

        if (rst_busy)                       ld_req <= 1'b0;
        else if (busy && ld_q && !ldac_n)   ld_req <= 1'b1;
        else if (load)                      ld_req <= 1'b0;

        if (do_clr) begin
          for (int i = 0; i < NCH; i++) dac_r[i] <= clr_r;
          dirty <= '0;
        end else if (load) begin
          for (int i = 0; i < NCH; i++)
            if (dirty[i]) begin
              dac_r[i] <= corr_r[i];
              dirty[i] <= 1'b0;
            end
        end

        if (calc_on) begin
          if (kcnt == '0) begin
            corr_r[cch] <= res;
            dirty[cch]  <= 1'b1;
            calc_on     <= 1'b0;
          end else begin
            kcnt <= kcnt - 1'b1;
          end
        end else if (|pend && !rst_busy) begin
          calc_on   <= 1'b1;
          cch       <= nxt;
          kcnt      <= KW'(CALC_CYC - 1);
          pend[nxt] <= 1'b0;
        end

        if (wr_ok) begin
          case (wr_sel)
            2'd0: in_r[wr_ch]   <= wr_data;
            2'd1: gain_r[wr_ch] <= wr_data;
            2'd2: off_r[wr_ch]  <= wr_data;
            default: clr_r      <= wr_data;
          endcase
          if (wr_sel != 2'd3) pend[wr_ch] <= 1'b1;
        end
      end
    end
  end
endmodule

module dac_update_ctrl_chk #(
  parameter int NCH = 40,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] wr_ch,
  input logic [1:0]    wr_sel,
  input logic          sreset_n,
  input logic          clr_n,
  input logic          busy_n,
  input logic [CW-1:0] rd_ch,
  input logic [DW-1:0] rd_code,
  input logic [DW-1:0] clr_r
);
  localparam logic [CW:0] NCH_V = (CW+1)'(NCH);

  assert_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && wr_en && wr_sel != 2'd3 && {1'b0, wr_ch} < NCH_V) |=> !busy_n);

  assert_reset_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sreset_n) && busy_n) |=> !busy_n);

  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy_n) && $past(clr_n) && !($past(sreset_n, 2) && !$past(sreset_n))
     && $stable(rd_ch)) |-> $stable(rd_code));

  assert_clear_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr_n) && $past(busy_n) && !($past(sreset_n, 2) && !$past(sreset_n))
     && {1'b0, rd_ch} < NCH_V) |-> rd_code == $past(clr_r));
endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
  .sreset_n(sreset_n), .clr_n(clr_n), .busy_n(busy_n), .rd_ch(rd_ch),
  .rd_code(rd_code), .clr_r(clr_r)
);

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;
  localparam int RST_CYC = 20;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sreset_n = 1'b1, clr_n = 1'b1, ldac_n = 1'b1;
  logic [5:0] wr_ch = '0, rd_ch = '0;
  logic [1:0] wr_sel = '0;
  logic [11:0] wr_data = '0, rd_code;
  logic busy_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dac_update_ctrl #(.NCH(40), .DW(12), .RST_CYC(RST_CYC), .CALC_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .sreset_n(sreset_n), .clr_n(clr_n), .ldac_n(ldac_n),
    .busy_n(busy_n), .rd_ch(rd_ch), .rd_code(rd_code));

  // ch, input, gain, offset, expected corrected code
  localparam logic [53:0] VEC [6] = '{
    {6'd0,  12'd1000, 12'd4095, 12'd2048, 12'd1000},
    {6'd5,  12'd4095, 12'd2047, 12'd2048, 12'd2047},
    {6'd39, 12'd4000, 12'd4095, 12'd3000, 12'd4095},
    {6'd10, 12'd100,  12'd4095, 12'd0,    12'd0},
    {6'd20, 12'd2000, 12'd1023, 12'd2100, 12'd552},
    {6'd7,  12'd0,    12'd0,    12'd2065, 12'd17}
  };

  task automatic wr(input logic [5:0] ch, input logic [1:0] sel, input logic [11:0] d);
    @(negedge clk); wr_en = 1'b1; wr_ch = ch; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!busy_n && n < 1000) begin n++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_ldac();
    @(negedge clk); ldac_n = 1'b0;
    @(negedge clk); ldac_n = 1'b1;
  endtask

  task automatic chk(input string tag, input logic [5:0] ch, input logic [11:0] exp);
    rd_ch = ch; #1;
    checks++;
    if (rd_code !== exp) begin
      errors++;
      $display("FAIL %s ch%0d got %0d exp %0d", tag, ch, rd_code, exp);
    end
  endtask

  task automatic chk_busy(input string tag, input logic exp);
    #1; checks++;
    if (busy_n !== exp) begin
      errors++;
      $display("FAIL %s busy_n got %0b exp %0b", tag, busy_n, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_busy("R1 busy after power-on", 1'b0);
    begin
      int n = 0;
      while (!busy_n && n < 100) begin n++; @(negedge clk); #1; end
      checks++;
      if (n < RST_CYC - 1 || n > RST_CYC + 1) begin
        errors++;
        $display("FAIL R1 reset length got %0d exp %0d", n, RST_CYC);
      end
    end
    chk("R1 output zero", 6'd0, 12'd0);
    chk("R1 output zero", 6'd39, 12'd0);

    // R3 defaults: gain 4095, offset 2048
    wr(6'd3, 2'd0, 12'd1234);
    pulse_ldac(); wait_idle();
    chk("R3 default gain/offset", 6'd3, 12'd1234);

    // R6 table, LDAC pulsed while busy (R7 latch)
    foreach (VEC[k]) begin
      wr(VEC[k][53:48], 2'd1, VEC[k][35:24]);
      wr(VEC[k][53:48], 2'd2, VEC[k][23:12]);
      wr(VEC[k][53:48], 2'd0, VEC[k][47:36]);
      chk_busy("R5 busy after write", 1'b0);
      pulse_ldac();
      wait_idle();
      chk("R6 R7 corrected code", VEC[k][53:48], VEC[k][11:0]);
    end

    // R7 no load without LDAC
    wr(6'd0, 2'd0, 12'd1500);
    wait_idle(); repeat (3) @(negedge clk);
    chk("R7 no load without request", 6'd0, 12'd1000);
    pulse_ldac(); repeat (2) @(negedge clk);
    chk("R7 load while idle", 6'd0, 12'd1500);

    // R11 queue, R5 stable while busy
    wr(6'd1, 2'd0, 12'd11);
    wr(6'd2, 2'd0, 12'd22);
    wr(6'd8, 2'd0, 12'd33);
    pulse_ldac();
    chk_busy("R11 busy with queue", 1'b0);
    chk("R5 output held while busy", 6'd1, 12'd0);
    wait_idle();
    chk("R11 queued ch1", 6'd1, 12'd11);
    chk("R11 queued ch2", 6'd2, 12'd22);
    chk("R11 queued ch8", 6'd8, 12'd33);

    // R8 LDAC held low
    @(negedge clk); ldac_n = 1'b0;
    wr(6'd9, 2'd0, 12'd444);
    wait_idle();
    chk("R8 held load first", 6'd9, 12'd444);
    wr(6'd9, 2'd0, 12'd555);
    chk_busy("R5 busy on second write", 1'b0);
    wait_idle();
    chk("R8 held load second", 6'd9, 12'd555);
    @(negedge clk); ldac_n = 1'b1;

    // R10 clear, R9 dirty-only load
    wr(6'd0, 2'd3, 12'd2748);
    chk_busy("R10 clear value write no busy", 1'b1);
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
    @(negedge clk);
    chk("R10 clear ch0", 6'd0, 12'd2748);
    chk("R10 clear ch39", 6'd39, 12'd2748);
    chk("R10 clear ch9", 6'd9, 12'd2748);
    pulse_ldac(); repeat (2) @(negedge clk);
    chk("R9 no load of unchanged ch0", 6'd0, 12'd2748);
    wr(6'd0, 2'd0, 12'd200);
    pulse_ldac(); wait_idle();
    chk("R9 changed ch0 loaded", 6'd0, 12'd200);
    chk("R9 unchanged ch39 kept", 6'd39, 12'd2748);

    // R2 R3 R4 soft reset
    @(negedge clk); sreset_n = 1'b0;
    @(negedge clk);
    chk_busy("R4 busy during soft reset", 1'b0);
    chk("R3 output cleared by reset", 6'd0, 12'd0);
    wr(6'd3, 2'd0, 12'd500);
    pulse_ldac();
    wait_idle();
    pulse_ldac(); wait_idle();
    chk("R4 write during reset dropped", 6'd3, 12'd0);
    wr(6'd5, 2'd0, 12'd4095);
    wr(6'd39, 2'd0, 12'd100);
    pulse_ldac(); wait_idle();
    chk("R3 R2 gain restored, low level ignored", 6'd5, 12'd4095);
    chk("R3 offset restored", 6'd39, 12'd100);
    @(negedge clk); sreset_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_busy("R2 rising edge no reset", 1'b1);
    chk("R2 rising edge keeps outputs", 6'd5, 12'd4095);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule